// File: doc/BRIEF.md
# Frequency-Dependent Gain Compensation Stage

This stage sits after a quadrature sine/cosine generator. It multiplies both samples of each pair by one gain. The gain depends on the frequency being synthesised. The top bits of the phase-increment word select an entry in a small writable gain table. This lets the chip boost or cut the signal as the frequency changes, so that roll-off in the analog filters and converters further down the chain is corrected before the signal reaches them.

The generator takes a fixed number of cycles to turn a new increment into samples. For that reason the table index is not applied at once. It runs through a delay line as long as the generator's latency. Each sample pair is therefore scaled by the gain that belongs to the increment that produced it. The table is loaded through a simple synchronous write port, and after reset every entry holds unity gain.

Top module: `freq_gain_comp`

## Requirements
- R1: After reset, outValid is low and both outputs are zero. Every one of the 256 table entries then holds unity gain, 0x8000, so valid samples pass through unchanged.
- R2: The table index is the top 8 bits of the 32-bit increment word, incWord[31:24]. The lower 24 bits have no effect on the gain chosen.
- R3: A sample pair captured on a clock edge is scaled by the entry selected by the incWord value present at the edge 31 edges earlier.
- R4: The sine and cosine samples of a pair are scaled by the same table entry. Equal inputs therefore give equal outputs.
- R5: The gain is an unsigned Q1.15 value. Each output is computed as (x*g + 2^14) >>> 15, where x is the signed 16-bit sample and the shift is arithmetic. This rounds to nearest, with ties toward plus infinity. A non-negative sample never yields a negative result.
- R6: Results above 32767 are clamped to 32767. Results below -32768 are clamped to -32768.
- R7: outValid equals inValid delayed by one clock. The scaled pair appears on the outputs at the same edge that captures the sample.
- R8: While inValid is low, sinOut and cosOut keep their last values.
- R9: On a clock edge with tblWrEn high, entry tblWrAddr takes the value tblWrData. Samples captured on later edges use the new value, and all other entries stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| incWord | input | 32 | Phase-increment word fed to the generator |
| sinIn | input | 16 | Sine sample, two's complement |
| cosIn | input | 16 | Cosine sample, two's complement |
| inValid | input | 1 | Sample pair strobe |
| tblWrEn | input | 1 | Gain table write enable |
| tblWrAddr | input | 8 | Gain table write address |
| tblWrData | input | 16 | Gain value, unsigned Q1.15 |
| sinOut | output | 16 | Scaled sine, two's complement |
| cosOut | output | 16 | Scaled cosine, two's complement |
| outValid | output | 1 | Scaled pair strobe |

## Verification
The assertions assume that reset is asserted before the first sample, and that inValid, sinIn and cosIn are known at every sampled edge. The bench drives every input on the falling clock edge, holds inValid low through reset, and always gives inputs defined values. The alignment checks also assume that incWord stayed steady for at least 31 edges before the change under test. Each scenario therefore waits out the full delay after setting an index, and only then sends samples.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  // Strobes the control passes to the datapath
  typedef struct packed {
    logic load;      // capture a scaled sample pair
    logic tblWrite;  // write a gain table entry
  } fgcStrobe_t;
endpackage

// File: rtl/fgc_ctrl.sv
module fgc_ctrl
  import fgc_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int DEPTH = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] incIdx,
  input  logic             inValid,
  input  logic             tblWrEn,
  output fgcStrobe_t       strobe,
  output logic [IDX_W-1:0] alignedIdx,
  output logic             outValid
);
  // Index delay line that matches the generator latency
  logic [IDX_W-1:0] idxPipe [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) idxPipe[i] <= '0;
    end else begin
      idxPipe[0] <= incIdx;
      for (int i = 1; i < DEPTH; i++) idxPipe[i] <= idxPipe[i-1];
    end
  end

  assign alignedIdx = idxPipe[DEPTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  always_comb begin
    strobe.load     = inValid;
    strobe.tblWrite = tblWrEn;
  end
endmodule

// File: rtl/fgc_table.sv
module fgc_table #(
  parameter int IDX_W  = 8,
  parameter int GAIN_W = 16,
  parameter logic [GAIN_W-1:0] UNITY = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [GAIN_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [GAIN_W-1:0] rdData
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [GAIN_W-1:0] gainMem [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) gainMem[i] <= UNITY;
    end else if (wrEn) begin
      gainMem[wrAddr] <= wrData;
    end
  end

  assign rdData = gainMem[rdAddr];
endmodule

// File: rtl/fgc_datapath.sv
module fgc_datapath
  import fgc_pkg::*;
#(
  parameter int SAMP_W = 16,
  parameter int GAIN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fgcStrobe_t        strobe,
  input  logic [GAIN_W-1:0] gain,
  input  logic [SAMP_W-1:0] sinIn,
  input  logic [SAMP_W-1:0] cosIn,
  output logic [SAMP_W-1:0] sinOut,
  output logic [SAMP_W-1:0] cosOut
);
  localparam int FRAC   = GAIN_W - 1;
  localparam int PROD_W = SAMP_W + GAIN_W + 1;
  localparam int LANES  = 2;
  localparam logic signed [PROD_W-1:0] MAX_V = (PROD_W'(1) <<< (SAMP_W-1)) - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] MIN_V = -MAX_V - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] HALF  = PROD_W'(1) <<< (FRAC-1);

  logic [SAMP_W-1:0] laneIn  [LANES];
  logic [SAMP_W-1:0] laneOut [LANES];

  assign laneIn[0] = sinIn;
  assign laneIn[1] = cosIn;

  logic signed [PROD_W-1:0] gainExt;
  assign gainExt = $signed({{(PROD_W-GAIN_W){1'b0}}, gain});

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [PROD_W-1:0] sampExt, prod, shifted;
    logic        [SAMP_W-1:0] satVal, outQ;

    assign sampExt = PROD_W'($signed(laneIn[l]));
    assign prod    = sampExt * gainExt;
    assign shifted = (prod + HALF) >>> FRAC;

    always_comb begin
      if (shifted > MAX_V)      satVal = MAX_V[SAMP_W-1:0];
      else if (shifted < MIN_V) satVal = MIN_V[SAMP_W-1:0];
      else                      satVal = shifted[SAMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            outQ <= '0;
      else if (strobe.load) outQ <= satVal;
    end

    assign laneOut[l] = outQ;
  end

  assign sinOut = laneOut[0];
  assign cosOut = laneOut[1];
endmodule

// File: rtl/freq_gain_comp.sv
module freq_gain_comp
  import fgc_pkg::*;
#(
  parameter int INC_W       = 32,
  parameter int IDX_W       = 8,
  parameter int SAMP_W      = 16,
  parameter int GAIN_W      = 16,
  parameter int ALIGN_DEPTH = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INC_W-1:0]  incWord,
  input  logic [SAMP_W-1:0] sinIn,
  input  logic [SAMP_W-1:0] cosIn,
  input  logic              inValid,
  input  logic              tblWrEn,
  input  logic [IDX_W-1:0]  tblWrAddr,
  input  logic [GAIN_W-1:0] tblWrData,
  output logic [SAMP_W-1:0] sinOut,
  output logic [SAMP_W-1:0] cosOut,
  output logic              outValid
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << (GAIN_W-1);

  logic [IDX_W-1:0]  incIdx, alignedIdx;
  logic [GAIN_W-1:0] gain;
  logic              unusedIncLow;
  fgcStrobe_t        strobe;

  assign incIdx       = incWord[INC_W-1 -: IDX_W];
  assign unusedIncLow = ^incWord[INC_W-IDX_W-1:0];

  fgc_ctrl #(.IDX_W(IDX_W), .DEPTH(ALIGN_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .incIdx(incIdx), .inValid(inValid),
    .tblWrEn(tblWrEn), .strobe(strobe), .alignedIdx(alignedIdx),
    .outValid(outValid)
  );

  fgc_table #(.IDX_W(IDX_W), .GAIN_W(GAIN_W), .UNITY(UNITY)) u_table (
    .clk(clk), .rstN(rstN), .wrEn(strobe.tblWrite), .wrAddr(tblWrAddr),
    .wrData(tblWrData), .rdAddr(alignedIdx), .rdData(gain)
  );

  fgc_datapath #(.SAMP_W(SAMP_W), .GAIN_W(GAIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .gain(gain),
    .sinIn(sinIn), .cosIn(cosIn), .sinOut(sinOut), .cosOut(cosOut)
  );
endmodule

// File: rtl/fgc_checker.sv
module fgc_checker #(
  parameter int SAMP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [SAMP_W-1:0] sinIn,
  input logic [SAMP_W-1:0] cosIn,
  input logic [SAMP_W-1:0] sinOut,
  input logic [SAMP_W-1:0] cosOut,
  input logic              outValid
);
  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(sinOut) && $stable(cosOut)));

  assert_sign_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !sinIn[SAMP_W-1]) |=> !sinOut[SAMP_W-1]);

  assert_pair_matched_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (sinIn == cosIn)) |=> (sinOut == cosOut));
endmodule

bind freq_gain_comp fgc_checker #(.SAMP_W(SAMP_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .sinIn(sinIn), .cosIn(cosIn),
  .sinOut(sinOut), .cosOut(cosOut), .outValid(outValid)
);

// File: tb/freq_gain_comp_tb.sv
module freq_gain_comp_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] incWord = '0;
  logic [15:0] sinIn = '0, cosIn = '0;
  logic        inValid = 1'b0;
  logic        tblWrEn = 1'b0;
  logic [7:0]  tblWrAddr = '0;
  logic [15:0] tblWrData = '0;
  logic [15:0] sinOut, cosOut;
  logic        outValid;

  int compared = 0;
  int mismatched = 0;

  freq_gain_comp u_dut (
    .clk(clk), .rstN(rstN), .incWord(incWord), .sinIn(sinIn), .cosIn(cosIn),
    .inValid(inValid), .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr),
    .tblWrData(tblWrData), .sinOut(sinOut), .cosOut(cosOut), .outValid(outValid)
  );

  always #2 clk = ~clk;

  function automatic int model(int x, int g);
    longint p;
    p = (longint'(x) * longint'(g) + 64'sd16384) >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sv(logic [15:0] v);
    return int'($signed(v));
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic writeGain(logic [7:0] a, logic [15:0] g);
    tblWrEn = 1'b1; tblWrAddr = a; tblWrData = g;
    @(posedge clk); @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  // Present the index and wait out the alignment delay
  task automatic setIndex(logic [7:0] idx, logic [23:0] low);
    incWord = {idx, low};
    repeat (32) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendPair(string req, int s, int c, int g);
    sinIn = 16'(s); cosIn = 16'(c); inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    check(req, "sinOut", sv(sinOut), model(s, g));
    check(req, "cosOut", sv(cosOut), model(c, g));
  endtask

  task automatic testReset();
    check("R1", "outValid after reset", int'(outValid), 0);
    check("R1", "sinOut after reset", sv(sinOut), 0);
    check("R1", "cosOut after reset", sv(cosOut), 0);
  endtask

  task automatic testUnity();
    setIndex(8'h00, 24'h0);
    sendPair("R1", 12345, -23456, 32768);
    setIndex(8'hFF, 24'hABCDEF);
    sendPair("R1", -32768, 32767, 32768);
    sendPair("R1", 1, -1, 32768);
  endtask

  task automatic testIndex();
    writeGain(8'h12, 16'h4000);
    writeGain(8'h13, 16'h2000);
    setIndex(8'h12, 24'hFFFFFF);
    sendPair("R2", 1000, -1000, 16'h4000);
    setIndex(8'h13, 24'h000000);
    sendPair("R2", 1000, 800, 16'h2000);
    setIndex(8'h11, 24'h5A5A5A);
    sendPair("R9", 1000, -700, 32768);
  endtask

  task automatic testAlign();
    setIndex(8'h12, 24'h0);
    incWord = {8'h00, 24'h0};
    sinIn = 16'd1000; cosIn = 16'd1000; inValid = 1'b1;
    for (int j = 0; j <= 40; j++) begin
      @(posedge clk); @(negedge clk);
      check("R3", $sformatf("sinOut step %0d", j), sv(sinOut),
            (j >= 31) ? 1000 : 500);
      check("R4", $sformatf("cosOut step %0d", j), sv(cosOut),
            (j >= 31) ? 1000 : 500);
    end
    inValid = 1'b0;
  endtask

  task automatic testRound();
    writeGain(8'h20, 16'h4000);
    writeGain(8'h21, 16'h6000);
    setIndex(8'h20, 24'h1);
    sendPair("R5", 3, -3, 16'h4000);
    check("R5", "3 at half gain", sv(sinOut), 2);
    check("R5", "-3 at half gain", sv(cosOut), -1);
    sendPair("R5", 1, -1, 16'h4000);
    sendPair("R4", -777, -777, 16'h4000);
    check("R4", "equal pair", sv(sinOut), sv(cosOut));
    setIndex(8'h21, 24'h2);
    sendPair("R5", 7, -7, 16'h6000);
  endtask

  task automatic testSat();
    writeGain(8'h30, 16'hFFFF);
    writeGain(8'h31, 16'h0000);
    setIndex(8'h30, 24'h0);
    sendPair("R6", 32767, -32768, 16'hFFFF);
    check("R6", "positive clamp", sv(sinOut), 32767);
    check("R6", "negative clamp", sv(cosOut), -32768);
    sendPair("R6", 100, -20000, 16'hFFFF);
    setIndex(8'h31, 24'h0);
    sendPair("R9", 30000, -30000, 0);
  endtask

  task automatic testValid();
    setIndex(8'h00, 24'h0);
    sinIn = 16'd5; cosIn = 16'd6; inValid = 1'b1;
    #1 check("R7", "outValid before edge", int'(outValid), 0);
    @(posedge clk); @(negedge clk);
    check("R7", "outValid after valid edge", int'(outValid), 1);
    check("R7", "sinOut same edge", sv(sinOut), 5);
    inValid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7", "outValid after idle edge", int'(outValid), 0);
  endtask

  task automatic testHold();
    setIndex(8'h00, 24'h0);
    sendPair("R8", 4321, -1234, 32768);
    sinIn = 16'd99; cosIn = 16'd77; inValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", "sinOut held", sv(sinOut), 4321);
    check("R8", "cosOut held", sv(cosOut), -1234);
  endtask

  task automatic testWriteEffect();
    setIndex(8'h40, 24'h0);
    sendPair("R9", 2000, 2000, 32768);
    writeGain(8'h40, 16'h4000);
    sendPair("R9", 2000, -2000, 16'h4000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnity();
    testIndex();
    testAlign();
    testRound();
    testSat();
    testValid();
    testHold();
    testWriteEffect();
    finishRun();
  end
endmodule